// File: doc/BRIEF.md
# Whole-Page Hamming ECC Engine

This engine watches the data bus between a controller and a NAND flash device and builds a single-error-correcting, double-error-detecting Hamming code over the data area of an entire page, in one step rather than in small chunks. Each bus beat is one byte in 8-bit mode or one 16-bit word in 16-bit mode. When a page is programmed, the engine folds every data beat into a pair of 16-bit parity accumulators. After the last data beat, software reads the two accumulators back as the 4-byte code and stores it in the spare area.

When a page is read, the stored 4-byte code must follow the page data directly on the bus. The engine compares the stored code with the code it has recomputed. It then classifies the outcome as clean, a single correctable data error, a single flipped bit inside the code itself, or a multiple error. For a correctable data error it gives the word address and bit offset of the faulty bit. A freshly erased page (all 0xFF) produces a distinctive all-ones location together with the multiple-error flag, so software can tell it apart from real damage. Patching the data buffer and sequencing the flash commands are left to the surrounding system.

A small register port, addressed by `regAddr`, holds the following. Writes are ignored except where noted. Reads of other addresses return 0.
- Address 0 is the clear strobe (write only).
- Address 1 is the mode register.
- Address 2 is the parity register.
- Address 3 is the complementary-parity register.
- Address 4 is the status register.

Top module: `ecc_page_top`

## Requirements
- R1: After reset, and in the cycle after a write to address 0 with data bit 0 set, the parity, complementary-parity and status registers read 0. The beat counters restart at the first data beat.
- R2: The mode register (address 1) is written and read back on bits [2:0]. Bits [1:0] = n select a data area of 512<<n bytes, which is a full page of 528, 1056, 2112 or 4224 bytes including spare. Bit 2 = 1 selects the 16-bit bus; there a data area of B bytes is B/2 beats, and in 8-bit mode it is B beats. Only dataIn[7:0] counts in 8-bit mode.
- R3: A data bit at beat index w (12 bits) and bit position b (4 bits) has location L = {w, b}. The parity register equals the XOR of L over all 1 data bits. The complementary-parity register equals the XOR of ~L over the same bits.
- R4: On a read (dataRead = 1 at the last data beat), the stored code follows the data directly. In 8-bit mode it comes as four bytes in this order: parity low, parity high, complement low, complement high. In 16-bit mode it comes as two words in this order: parity, then complement. Code beats are not added to the parity.
- R5: A read whose stored code matches the data leaves status = 0 and both parity registers = 0. Status bit 0 is recoverable error, bit 1 is error inside the code, and bit 2 is multiple error.
- R6: After a read, the parity register holds the parity syndrome S (stored XOR computed) and the complement register holds its complementary syndrome C. If S XOR C is all ones, status is 1. Then S[3:0] is the bit offset and S[15:4] is the beat (byte or 16-bit word) address of the single faulty data bit.
- R7: If exactly one bit of {C, S} is set, status is 3 (the error lies in the code bytes).
- R8: Any other nonzero syndrome gives status 5. A fully erased page, with all data and code bytes 0xFF, gives status 5 and a parity register of 0xFFFF.
- R9: `done` is high for exactly one cycle. On a write it follows the last data beat. On a read it follows the last code beat.
- R10: After `done`, further beats change no register and raise no `done` until the next clear.
- R11: The code-error and multiple-error flags are never set together, and neither is set without the recoverable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address for reads and writes |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 3 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` (combinational) |
| dataValid | input | 1 | One bus beat is present on `dataIn` |
| dataRead | input | 1 | 1 when the page is being read from flash |
| dataIn | input | 16 | Bus beat; only bits [7:0] in 8-bit mode |
| done | output | 1 | One-cycle pulse at the end of a page operation |

## Verification
The assertions take for granted that the mode register is not rewritten in the middle of a page. They also assume that each page operation starts with a clear, and that `dataRead` is steady from the first data beat to the last code beat. The stimulus respects all three: every page begins with a mode write followed by a clear, and `dataRead` is held for the whole stream. Random page contents come from a fixed-seed generator. In 8-bit mode the unused upper byte of `dataIn` is filled with random bits so that it is exercised. Corner cases are directed: single flips at random positions, one flip in the code, two data flips, and erased pages of 512 bytes (8-bit) and 4096 bytes (16-bit).

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  parameter int ADDR_W     = 12;   // beat address bits
  parameter int BIT_W      = 4;    // bit offset bits
  parameter int BUS_W      = 16;   // widest bus beat
  parameter int BYTE_W     = 8;
  parameter int SEL_W      = 2;    // page size select
  parameter int BASE_BYTES = 512;  // smallest data area
  localparam int PAR_W     = ADDR_W + BIT_W;
  localparam int LEN_W     = ADDR_W + 1;
  localparam int MODE_W    = SEL_W + 1;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_CODE = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  typedef struct packed {
    logic              clr;
    logic              accum;
    logic              capture;
    logic              finishRd;
    logic [1:0]        capIdx;
    logic [ADDR_W-1:0] wordIdx;
  } eccStrobe_t;

  typedef struct packed {
    logic mulErr;
    logic codeErr;
    logic recErr;
  } eccStatus_t;
endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regAddr,
  input  logic                regWr,
  input  logic [MODE_W-1:0]   regWrData,
  input  logic                dataValid,
  input  logic                dataRead,
  output eccStrobe_t          strb,
  output logic [MODE_W-1:0]   modeReg,
  output logic                done
);
  logic [SEL_W-1:0]  pageSel;
  logic              wide;
  phase_t            phase;
  logic [ADDR_W-1:0] wordCnt;
  logic [1:0]        codeCnt;
  logic              clrReq, modeWr, lastData, lastCode;
  logic [LEN_W-1:0]  lenBytes, lenBeats;
  logic [ADDR_W-1:0] lastWord;

  assign modeReg  = {wide, pageSel};
  assign clrReq   = regWr && (regAddr == 3'd0) && regWrData[0];
  assign modeWr   = regWr && (regAddr == 3'd1);
  assign lenBytes = LEN_W'(BASE_BYTES) << pageSel;
  assign lenBeats = wide ? (lenBytes >> 1) : lenBytes;
  assign lastWord = ADDR_W'(lenBeats - LEN_W'(1));
  assign lastData = (wordCnt == lastWord);
  assign lastCode = wide ? (codeCnt == 2'd1) : (codeCnt == 2'd3);

  always_comb begin
    strb          = '0;
    strb.clr      = clrReq;
    strb.wordIdx  = wordCnt;
    strb.capIdx   = codeCnt;
    if (!clrReq && dataValid) begin
      case (phase)
        PH_DATA: strb.accum = 1'b1;
        PH_CODE: begin
          strb.capture  = 1'b1;
          strb.finishRd = lastCode;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageSel <= '0;
      wide    <= 1'b0;
      phase   <= PH_DATA;
      wordCnt <= '0;
      codeCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (modeWr) begin
        pageSel <= regWrData[SEL_W-1:0];
        wide    <= regWrData[SEL_W];
      end
      if (clrReq) begin
        phase   <= PH_DATA;
        wordCnt <= '0;
        codeCnt <= '0;
      end else if (dataValid) begin
        case (phase)
          PH_DATA: begin
            if (lastData) begin
              wordCnt <= '0;
              if (dataRead) begin
                phase <= PH_CODE;
              end else begin
                phase <= PH_DONE;
                done  <= 1'b1;
              end
            end else begin
              wordCnt <= wordCnt + ADDR_W'(1);
            end
          end
          PH_CODE: begin
            if (lastCode) begin
              codeCnt <= '0;
              phase   <= PH_DONE;
              done    <= 1'b1;
            end else begin
              codeCnt <= codeCnt + 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> !(strb.accum || strb.capture)); // R10
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  eccStrobe_t       strb,
  input  logic             wide,
  input  logic [BUS_W-1:0] dataIn,
  output logic [PAR_W-1:0] parOut,
  output logic [PAR_W-1:0] nparOut,
  output eccStatus_t       status
);
  logic [PAR_W-1:0] accP, accN, storedP, storedN;
  logic [PAR_W-1:0] beatP, beatN, codePNext, codeNNext, synP, synN;
  logic [2*PAR_W-1:0] syn;
  eccStatus_t statusNext;

  // Location-weighted parity of one beat
  always_comb begin
    beatP = '0;
    beatN = '0;
    for (int b = 0; b < BUS_W; b++) begin
      if ((wide || b < BYTE_W) && dataIn[b]) begin
        beatP = beatP ^ {strb.wordIdx, BIT_W'(b)};
        beatN = beatN ^ ~{strb.wordIdx, BIT_W'(b)};
      end
    end
  end

  // Stored code with the current code beat merged in
  always_comb begin
    codePNext = storedP;
    codeNNext = storedN;
    if (strb.capture) begin
      if (wide) begin
        if (strb.capIdx[0]) codeNNext = dataIn;
        else                codePNext = dataIn;
      end else begin
        case (strb.capIdx)
          2'd0: codePNext[BYTE_W-1:0]     = dataIn[BYTE_W-1:0];
          2'd1: codePNext[PAR_W-1:BYTE_W] = dataIn[BYTE_W-1:0];
          2'd2: codeNNext[BYTE_W-1:0]     = dataIn[BYTE_W-1:0];
          default: codeNNext[PAR_W-1:BYTE_W] = dataIn[BYTE_W-1:0];
        endcase
      end
    end
  end

  assign synP = codePNext ^ accP;
  assign synN = codeNNext ^ accN;
  assign syn  = {synN, synP};

  always_comb begin
    statusNext = '0;
    if (syn != '0) begin
      statusNext.recErr = 1'b1;
      if ((synP ^ synN) == '1) begin
        statusNext.codeErr = 1'b0;
      end else if ((syn & (syn - 1'b1)) == '0) begin
        statusNext.codeErr = 1'b1;
      end else begin
        statusNext.mulErr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accP <= '0; accN <= '0; storedP <= '0; storedN <= '0; status <= '0;
    end else if (strb.clr) begin
      accP <= '0; accN <= '0; storedP <= '0; storedN <= '0; status <= '0;
    end else begin
      if (strb.accum) begin
        accP <= accP ^ beatP;
        accN <= accN ^ beatN;
      end
      if (strb.capture) begin
        storedP <= codePNext;
        storedN <= codeNNext;
      end
      if (strb.finishRd) begin
        accP   <= synP;
        accN   <= synN;
        status <= statusNext;
      end
    end
  end

  assign parOut  = accP;
  assign nparOut = accN;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (accP == '0 && accN == '0 && status == '0)); // R1
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(status.codeErr && status.mulErr)); // R11
  AST_FLAG_NEEDS_REC: assert property (@(posedge clk) disable iff (!rstN)
    (status.codeErr || status.mulErr) |-> status.recErr); // R11
  AST_NO_ACCUM_ON_CODE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !strb.accum); // R4
endmodule

// File: rtl/ecc_page_top.sv
module ecc_page_top
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWr,
  input  logic [MODE_W-1:0] regWrData,
  output logic [PAR_W-1:0]  regRdData,
  input  logic              dataValid,
  input  logic              dataRead,
  input  logic [BUS_W-1:0]  dataIn,
  output logic              done
);
  eccStrobe_t        strb;
  logic [MODE_W-1:0] modeReg;
  logic [PAR_W-1:0]  parOut, nparOut;
  eccStatus_t        status;

  ecc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .dataValid(dataValid), .dataRead(dataRead),
    .strb(strb), .modeReg(modeReg), .done(done)
  );

  ecc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wide(modeReg[SEL_W]),
    .dataIn(dataIn), .parOut(parOut), .nparOut(nparOut), .status(status)
  );

  always_comb begin
    case (regAddr)
      3'd1:    regRdData = PAR_W'(modeReg);
      3'd2:    regRdData = parOut;
      3'd3:    regRdData = nparOut;
      3'd4:    regRdData = PAR_W'(status);
      default: regRdData = '0;
    endcase
  end
endmodule

// File: tb/ecc_page_top_bench.sv
module ecc_page_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regWrData = '0;
  logic [15:0] regRdData;
  logic        dataValid = 1'b0;
  logic        dataRead = 1'b0;
  logic [15:0] dataIn = '0;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] mem [0:4095];

  ecc_page_top u_ecc_page_top (.*);

  always #5 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [2:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic beat(logic [15:0] d);
    dataIn = d; dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  function automatic logic [31:0] modelCode(int nBeats, bit wide);
    logic [15:0] p = '0;
    logic [15:0] n = '0;
    for (int w = 0; w < nBeats; w++)
      for (int b = 0; b < (wide ? 16 : 8); b++)
        if (mem[w][b]) begin
          p ^= {12'(w), 4'(b)};
          n ^= ~{12'(w), 4'(b)};
        end
    return {n, p};
  endfunction

  function automatic int beatsOf(int sel, bit wide);
    return wide ? (256 << sel) : (512 << sel);
  endfunction

  task automatic startPage(int sel, bit wide);
    regWrite(3'd1, {wide, 2'(sel)});
    regWrite(3'd0, 3'd1);
  endtask

  task automatic fillRandom(int n);
    for (int i = 0; i < n; i++) mem[i] = 16'($urandom);
  endtask

  task automatic streamData(int n, bit rd);
    dataRead = rd;
    for (int i = 0; i < n; i++) beat(mem[i]);
  endtask

  task automatic streamCode(logic [31:0] c, bit wide);
    if (wide) begin
      beat(c[15:0]); beat(c[31:16]);
    end else begin
      beat({8'($urandom), c[7:0]});   beat({8'($urandom), c[15:8]});
      beat({8'($urandom), c[23:16]}); beat({8'($urandom), c[31:24]});
    end
  endtask

  // Read a page with the given stored code and check status and parity
  task automatic readPage(int sel, bit wide, logic [31:0] code,
                          logic [2:0] expStat, bit chkPar, logic [15:0] expPar,
                          string req);
    logic [15:0] v;
    startPage(sel, wide);
    streamData(beatsOf(sel, wide), 1'b1);
    check(done === 1'b0, "R4 no done before code", int'(done), 0);
    streamCode(code, wide);
    check(done === 1'b1, "R9 done after code", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", int'(done), 0);
    regRead(3'd4, v);
    check(v === {13'd0, expStat}, req, int'(v), int'(expStat));
    if (chkPar) begin
      regRead(3'd2, v);
      check(v === expPar, req, int'(v), int'(expPar));
    end
    dataRead = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] code, exp;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 2; a <= 4; a++) begin
      regRead(3'(a), v);
      check(v === 16'h0, "R1 reset register", int'(v), 0);
    end

    // R2 mode readback
    regWrite(3'd1, 3'b110);
    regRead(3'd1, v);
    check(v === 16'h6, "R2 mode readback", int'(v), 6);

    // R3 write, 8-bit, 512 bytes
    fillRandom(512);
    startPage(0, 1'b0);
    streamData(512, 1'b0);
    check(done === 1'b1, "R9 done after write", int'(done), 1);
    exp = modelCode(512, 1'b0);
    regRead(3'd2, v);
    check(v === exp[15:0], "R3 parity 8-bit", int'(v), int'(exp[15:0]));
    regRead(3'd3, v);
    check(v === exp[31:16], "R3 complement 8-bit", int'(v), int'(exp[31:16]));
    @(negedge clk);
    check(done === 1'b0, "R9 write done one cycle", int'(done), 0);

    // R10 beats after done are ignored
    for (int i = 0; i < 5; i++) beat(16'($urandom) | 16'h1);
    check(done === 1'b0, "R10 no done after extra beats", int'(done), 0);
    regRead(3'd2, v);
    check(v === exp[15:0], "R10 parity unchanged", int'(v), int'(exp[15:0]));
    regRead(3'd3, v);
    check(v === exp[31:16], "R10 complement unchanged", int'(v), int'(exp[31:16]));

    // R1 clear
    regWrite(3'd0, 3'd1);
    regRead(3'd2, v);
    check(v === 16'h0, "R1 clear parity", int'(v), 0);

    // R3 write, 16-bit, 2048-byte area
    fillRandom(1024);
    startPage(2, 1'b1);
    streamData(1024, 1'b0);
    check(done === 1'b1, "R2 16-bit length", int'(done), 1);
    exp = modelCode(1024, 1'b1);
    regRead(3'd2, v);
    check(v === exp[15:0], "R3 parity 16-bit", int'(v), int'(exp[15:0]));
    regRead(3'd3, v);
    check(v === exp[31:16], "R3 complement 16-bit", int'(v), int'(exp[31:16]));

    // R2 largest 8-bit page: no done before the 4096th beat
    fillRandom(4096);
    startPage(3, 1'b0);
    dataRead = 1'b0;
    for (int i = 0; i < 4095; i++) beat(mem[i]);
    check(done === 1'b0, "R2 no early done", int'(done), 0);
    beat(mem[4095]);
    check(done === 1'b1, "R2 done at 4096 bytes", int'(done), 1);
    exp = modelCode(4096, 1'b0);
    regRead(3'd2, v);
    check(v === exp[15:0], "R3 parity 4096 bytes", int'(v), int'(exp[15:0]));

    // R5 clean reads
    for (int m = 0; m < 2; m++) begin
      bit wd = (m == 1);
      fillRandom(beatsOf(1, wd));
      code = modelCode(beatsOf(1, wd), wd);
      readPage(1, wd, code, 3'd0, 1'b1, 16'h0, "R5 clean read");
    end

    // R6 single data errors, both widths
    for (int k = 0; k < 6; k++) begin
      bit wd = k[0];
      int n = beatsOf(0, wd);
      int w = int'($urandom % n);
      int b = int'($urandom % (wd ? 16 : 8));
      fillRandom(n);
      code = modelCode(n, wd);
      mem[w][b] = ~mem[w][b];
      readPage(0, wd, code, 3'd1, 1'b1, {12'(w), 4'(b)}, "R6 single data error");
      regRead(3'd3, v);
      check(v === ~{12'(w), 4'(b)}, "R6 complement syndrome", int'(v),
            int'(~{12'(w), 4'(b)}));
    end

    // R7 one flipped code bit
    for (int k = 0; k < 2; k++) begin
      bit wd = k[0];
      int n = beatsOf(0, wd);
      int cb = int'($urandom % 32);
      fillRandom(n);
      code = modelCode(n, wd);
      code[cb] = ~code[cb];
      readPage(0, wd, code, 3'd3, 1'b0, 16'h0, "R7 code bit error");
    end

    // R8 two data errors
    begin
      int n = beatsOf(0, 1'b0);
      fillRandom(n);
      code = modelCode(n, 1'b0);
      mem[3][1] = ~mem[3][1];
      mem[200][6] = ~mem[200][6];
      readPage(0, 1'b0, code, 3'd5, 1'b0, 16'h0, "R8 double error");
    end

    // R8 erased pages
    for (int i = 0; i < 512; i++) mem[i] = 16'hFFFF;
    readPage(0, 1'b0, 32'hFFFF_FFFF, 3'd5, 1'b1, 16'hFFFF, "R8 erased 8-bit");
    for (int i = 0; i < 2048; i++) mem[i] = 16'hFFFF;
    readPage(3, 1'b1, 32'hFFFF_FFFF, 3'd5, 1'b1, 16'hFFFF, "R8 erased 16-bit");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule